// File: doc/BRIEF.md
# Micro-op affine loop sequencer

The sequencer turns one compute instruction into a stream of single-cycle tensor operation requests. A local buffer holds short micro-ops. Each micro-op carries three base indices: an accumulator (destination) index, an activation (source) index and a weight index. An instruction names a half-open range of buffer entries, two loop extents and one pair of stride factors for each of the three operands. The block runs an outer counter `y` and an inner counter `x`. For every `(y, x)` pair it replays the whole micro-op range in buffer order. Each operand index is formed as `a*y + b*x + base`.

Each request asks a downstream datapath to accumulate `acc[dst] += product(act[src], wgt[wgt])`. Requests leave through a valid/ready port from a registered output stage, at most one per cycle. When the last request has been taken, a one-cycle completion pulse is raised. With this scheme, a micro-kernel of a few entries can cover a whole tile of a convolution. The micro-op buffer is an internal array with a synchronous read port. It is written through its own write port while the sequencer is idle.

Top module: `uop_affine_seq`

## Requirements
- R1: After reset, `op_valid` and `done` are low and `ins_ready` is high.
- R2: For an instruction with range [`ins_ubeg`, `ins_uend`) and extents `ins_ext_i`, `ins_ext_j`, exactly `ext_i*ext_j*(uend-ubeg)` requests are issued. The order is: `y` outer from 0 to ext_i-1, `x` inner from 0 to ext_j-1, and micro-ops in ascending buffer order innermost.
- R3: `op_dst` equals `(ins_dst_a*y + ins_dst_b*x + uop.dst) mod 2^IDX_W`.
- R4: `op_src` and `op_wgt` use their own factor pairs (`ins_src_a/b`, `ins_wgt_a/b`) with the same affine form, modulo 2^IDX_W.
- R5: An instruction is accepted on `ins_valid && ins_ready`, and all of its fields are captured then. `ins_ready` stays low from the cycle after a non-empty acceptance up to and including the `done` cycle. Changing the instruction inputs during that time has no effect.
- R6: While `op_valid` is high and `op_ready` is low, `op_valid` stays high and the three index outputs hold their values. No request is lost or repeated.
- R7: `done` is high for exactly one cycle: the cycle after the handshake of the final request. `op_valid` is low in that cycle.
- R8: An extent of zero, or a range with `ins_uend <= ins_ubeg`, issues no request. `done` is raised in the cycle after acceptance.
- R9: A write with `uop_we` high stores {`uop_wdst`, `uop_wsrc`, `uop_wwgt`} at `uop_waddr`. Instructions accepted later use the new contents. `ins_uend` may be as large as UOP_DEPTH.
- R10: With `op_ready` held high, the first request is valid two cycles after acceptance. Requests then follow on consecutive cycles with no bubble, including at inner and outer loop wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| uop_we | input | 1 | Micro-op buffer write enable |
| uop_waddr | input | UOP_AW | Buffer write address |
| uop_wdst | input | IDX_W | Destination base written |
| uop_wsrc | input | IDX_W | Source base written |
| uop_wwgt | input | IDX_W | Weight base written |
| ins_valid | input | 1 | Instruction offered |
| ins_ready | output | 1 | Sequencer can accept an instruction |
| ins_ubeg | input | UOP_AW | First micro-op index |
| ins_uend | input | UOP_AW+1 | One past the last micro-op index |
| ins_ext_i | input | EXT_W | Outer loop extent |
| ins_ext_j | input | EXT_W | Inner loop extent |
| ins_dst_a | input | IDX_W | Destination outer factor |
| ins_dst_b | input | IDX_W | Destination inner factor |
| ins_src_a | input | IDX_W | Source outer factor |
| ins_src_b | input | IDX_W | Source inner factor |
| ins_wgt_a | input | IDX_W | Weight outer factor |
| ins_wgt_b | input | IDX_W | Weight inner factor |
| op_valid | output | 1 | Request valid |
| op_ready | input | 1 | Downstream takes the request |
| op_dst | output | IDX_W | Accumulator index |
| op_src | output | IDX_W | Activation index |
| op_wgt | output | IDX_W | Weight index |
| done | output | 1 | One-cycle completion pulse |

## Verification
A loop wrap can occur in the same cycle as a downstream stall. In that case the counter step, the accumulator update and the buffer read lookahead must all freeze together. The bench provokes this by running half of the sweep with a pseudo-random `op_ready` over ranges and extents chosen so that wraps happen often. Every handshake is compared against an arithmetic nested-loop model, and any change of the outputs while stalled is flagged.

The final handshake and the completion pulse also meet. The bench checks that `done` arrives exactly one cycle after that handshake, and one cycle after acceptance for empty jobs.

// File: rtl/uop_seq_pkg.sv
package uop_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_RUN   = 2'd1,
    PH_DRAIN = 2'd2
  } seq_phase_e;

  localparam int NUM_OPND = 3;
  localparam int OPND_DST = 0;
  localparam int OPND_SRC = 1;
  localparam int OPND_WGT = 2;
endpackage

// File: rtl/uop_ram.sv
module uop_ram #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 33,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/affine_term.sv
module affine_term #(
  parameter int IDX_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [IDX_W-1:0] a_in,
  input  logic [IDX_W-1:0] b_in,
  input  logic             col_step,
  input  logic             row_step,
  input  logic [IDX_W-1:0] base,
  output logic [IDX_W-1:0] idx
);
  logic [IDX_W-1:0] a_q, b_q, row_acc, col_acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q     <= '0;
      b_q     <= '0;
      row_acc <= '0;
      col_acc <= '0;
    end else if (load) begin
      a_q     <= a_in;
      b_q     <= b_in;
      row_acc <= '0;
      col_acc <= '0;
    end else if (row_step) begin
      row_acc <= row_acc + a_q;
      col_acc <= '0;
    end else if (col_step) begin
      col_acc <= col_acc + b_q;
    end
  end

  assign idx = base + row_acc + col_acc;

  // R3: right after a load both running terms are zero, so the index is the base alone
  p_origin_r3: assert property (@(posedge clk) disable iff (rst)
    load |=> (idx == base));
endmodule

// File: rtl/uop_loop_ctrl.sv
module uop_loop_ctrl
  import uop_seq_pkg::*;
#(
  parameter int UOP_AW = 4,
  parameter int EXT_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ins_valid,
  input  logic [UOP_AW-1:0] ins_ubeg,
  input  logic [UOP_AW:0]   ins_uend,
  input  logic [EXT_W-1:0]  ins_ext_i,
  input  logic [EXT_W-1:0]  ins_ext_j,
  input  logic              op_valid,
  input  logic              op_ready,
  output logic              ins_ready,
  output logic              start,
  output logic              fire,
  output logic              col_step,
  output logic              row_step,
  output logic [UOP_AW-1:0] rd_addr,
  output logic              done
);
  localparam logic [UOP_AW-1:0] ONE_A = 1;
  localparam logic [UOP_AW:0]   ONE_P = 1;
  localparam logic [EXT_W-1:0]  ONE_E = 1;

  seq_phase_e        phase_q;
  logic [UOP_AW-1:0] ptr_q, beg_q, ptr_nxt;
  logic [UOP_AW:0]   end_q;
  logic [EXT_W-1:0]  x_q, y_q, ei_q, ej_q;
  logic              empty_job, last_uop, last_x, last_y;

  assign ins_ready = (phase_q == PH_IDLE) && !done;
  assign start     = ins_valid && ins_ready;
  assign empty_job = (ins_ext_i == '0) || (ins_ext_j == '0) || (ins_uend <= {1'b0, ins_ubeg});
  assign fire      = (phase_q == PH_RUN) && (!op_valid || op_ready);
  assign last_uop  = (({1'b0, ptr_q} + ONE_P) == end_q);
  assign last_x    = (x_q == ej_q - ONE_E);
  assign last_y    = (y_q == ei_q - ONE_E);
  assign ptr_nxt   = last_uop ? beg_q : ptr_q + ONE_A;
  assign col_step  = fire && last_uop && !last_x;
  assign row_step  = fire && last_uop && last_x;
  // read one entry ahead so the registered buffer output matches ptr_q
  assign rd_addr   = start ? ins_ubeg : (fire ? ptr_nxt : ptr_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      done    <= 1'b0;
      ptr_q   <= '0;
      beg_q   <= '0;
      end_q   <= '0;
      x_q     <= '0;
      y_q     <= '0;
      ei_q    <= '0;
      ej_q    <= '0;
    end else begin
      done <= 1'b0;
      case (phase_q)
        PH_IDLE: begin
          if (start) begin
            beg_q   <= ins_ubeg;
            end_q   <= ins_uend;
            ei_q    <= ins_ext_i;
            ej_q    <= ins_ext_j;
            ptr_q   <= ins_ubeg;
            x_q     <= '0;
            y_q     <= '0;
            phase_q <= empty_job ? PH_IDLE : PH_RUN;
            done    <= empty_job;
          end
        end
        PH_RUN: begin
          if (fire) begin
            ptr_q <= ptr_nxt;
            if (last_uop) begin
              if (last_x) begin
                x_q <= '0;
                y_q <= y_q + ONE_E;
                if (last_y) phase_q <= PH_DRAIN;
              end else begin
                x_q <= x_q + ONE_E;
              end
            end
          end
        end
        PH_DRAIN: begin
          if (op_ready) begin
            phase_q <= PH_IDLE;
            done    <= 1'b1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  p_counters_in_range_r2: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_RUN) |-> ((x_q < ej_q) && (y_q < ei_q)));

  p_busy_after_accept_r5: assert property (@(posedge clk) disable iff (rst)
    (start && !empty_job) |=> !ins_ready);

  p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_empty_done_r8: assert property (@(posedge clk) disable iff (rst)
    (start && empty_job) |=> (done && !op_valid));
endmodule

// File: rtl/uop_affine_seq.sv
module uop_affine_seq
  import uop_seq_pkg::*;
#(
  parameter int UOP_DEPTH = 16,
  parameter int IDX_W     = 11,
  parameter int EXT_W     = 6,
  localparam int UOP_AW   = $clog2(UOP_DEPTH),
  localparam int UOP_W    = NUM_OPND * IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              uop_we,
  input  logic [UOP_AW-1:0] uop_waddr,
  input  logic [IDX_W-1:0]  uop_wdst,
  input  logic [IDX_W-1:0]  uop_wsrc,
  input  logic [IDX_W-1:0]  uop_wwgt,
  input  logic              ins_valid,
  output logic              ins_ready,
  input  logic [UOP_AW-1:0] ins_ubeg,
  input  logic [UOP_AW:0]   ins_uend,
  input  logic [EXT_W-1:0]  ins_ext_i,
  input  logic [EXT_W-1:0]  ins_ext_j,
  input  logic [IDX_W-1:0]  ins_dst_a,
  input  logic [IDX_W-1:0]  ins_dst_b,
  input  logic [IDX_W-1:0]  ins_src_a,
  input  logic [IDX_W-1:0]  ins_src_b,
  input  logic [IDX_W-1:0]  ins_wgt_a,
  input  logic [IDX_W-1:0]  ins_wgt_b,
  output logic              op_valid,
  input  logic              op_ready,
  output logic [IDX_W-1:0]  op_dst,
  output logic [IDX_W-1:0]  op_src,
  output logic [IDX_W-1:0]  op_wgt,
  output logic              done
);
  logic              start, fire, col_step, row_step;
  logic [UOP_AW-1:0] rd_addr;
  logic [UOP_W-1:0]  uop_word;
  logic [IDX_W-1:0]  fac_a [NUM_OPND];
  logic [IDX_W-1:0]  fac_b [NUM_OPND];
  logic [IDX_W-1:0]  idx   [NUM_OPND];

  uop_ram #(.DEPTH(UOP_DEPTH), .WIDTH(UOP_W)) i_ram (
    .clk   (clk),
    .we    (uop_we),
    .waddr (uop_waddr),
    .wdata ({uop_wwgt, uop_wsrc, uop_wdst}),
    .raddr (rd_addr),
    .rdata (uop_word)
  );

  uop_loop_ctrl #(.UOP_AW(UOP_AW), .EXT_W(EXT_W)) i_ctrl (
    .clk       (clk),
    .rst       (rst),
    .ins_valid (ins_valid),
    .ins_ubeg  (ins_ubeg),
    .ins_uend  (ins_uend),
    .ins_ext_i (ins_ext_i),
    .ins_ext_j (ins_ext_j),
    .op_valid  (op_valid),
    .op_ready  (op_ready),
    .ins_ready (ins_ready),
    .start     (start),
    .fire      (fire),
    .col_step  (col_step),
    .row_step  (row_step),
    .rd_addr   (rd_addr),
    .done      (done)
  );

  assign fac_a[OPND_DST] = ins_dst_a;
  assign fac_b[OPND_DST] = ins_dst_b;
  assign fac_a[OPND_SRC] = ins_src_a;
  assign fac_b[OPND_SRC] = ins_src_b;
  assign fac_a[OPND_WGT] = ins_wgt_a;
  assign fac_b[OPND_WGT] = ins_wgt_b;

  for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
    affine_term #(.IDX_W(IDX_W)) i_term (
      .clk      (clk),
      .rst      (rst),
      .load     (start),
      .a_in     (fac_a[g]),
      .b_in     (fac_b[g]),
      .col_step (col_step),
      .row_step (row_step),
      .base     (uop_word[g*IDX_W +: IDX_W]),
      .idx      (idx[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)           op_valid <= 1'b0;
    else if (fire)     op_valid <= 1'b1;
    else if (op_ready) op_valid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (fire) begin
      op_dst <= idx[OPND_DST];
      op_src <= idx[OPND_SRC];
      op_wgt <= idx[OPND_WGT];
    end
  end

  p_stall_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !op_ready) |=> (op_valid && $stable(op_dst) && $stable(op_src) && $stable(op_wgt)));

  p_done_drained_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> !op_valid);
endmodule

// File: tb/test_uop_affine_seq.sv
module test_uop_affine_seq;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int IDX_W = 11;
  localparam int EXT_W = 6;
  localparam int AW    = 4;
  localparam int MASK  = (1 << IDX_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic uop_we = 1'b0;
  logic [AW-1:0] uop_waddr = '0;
  logic [IDX_W-1:0] uop_wdst = '0, uop_wsrc = '0, uop_wwgt = '0;
  logic ins_valid = 1'b0;
  logic ins_ready;
  logic [AW-1:0] ins_ubeg = '0;
  logic [AW:0] ins_uend = '0;
  logic [EXT_W-1:0] ins_ext_i = '0, ins_ext_j = '0;
  logic [IDX_W-1:0] ins_dst_a = '0, ins_dst_b = '0, ins_src_a = '0;
  logic [IDX_W-1:0] ins_src_b = '0, ins_wgt_a = '0, ins_wgt_b = '0;
  logic op_valid;
  logic op_ready = 1'b1;
  logic [IDX_W-1:0] op_dst, op_src, op_wgt;
  logic done;

  uop_affine_seq #(.UOP_DEPTH(DEPTH), .IDX_W(IDX_W), .EXT_W(EXT_W)) i_uop_affine_seq (
    .clk(clk), .rst(rst), .uop_we(uop_we), .uop_waddr(uop_waddr),
    .uop_wdst(uop_wdst), .uop_wsrc(uop_wsrc), .uop_wwgt(uop_wwgt),
    .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_ubeg(ins_ubeg), .ins_uend(ins_uend),
    .ins_ext_i(ins_ext_i), .ins_ext_j(ins_ext_j),
    .ins_dst_a(ins_dst_a), .ins_dst_b(ins_dst_b), .ins_src_a(ins_src_a),
    .ins_src_b(ins_src_b), .ins_wgt_a(ins_wgt_a), .ins_wgt_b(ins_wgt_b),
    .op_valid(op_valid), .op_ready(op_ready), .op_dst(op_dst), .op_src(op_src),
    .op_wgt(op_wgt), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int q_d[$], q_s[$], q_w[$];
  int m_d[DEPTH], m_s[DEPTH], m_w[DEPTH];
  bit full_ready = 1'b1;
  bit exp_zero = 1'b0;
  bit inflight = 1'b0;
  bit prev_stall = 1'b0;
  bit prev_done = 1'b0;
  int acc_cyc = 0;
  int last_hs = 0;
  int n_hs = 0;
  int done_cnt = 0;
  int sv_d, sv_s, sv_w;
  string dst_tag = "R3";

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  always begin
    @(posedge clk);
    #1;
    op_ready = full_ready ? 1'b1 : (($urandom % 3) != 0);
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (prev_stall) begin
        chk(op_valid, "R6", "valid held in stall", int'(op_valid), 1);
        chk(op_dst == sv_d[IDX_W-1:0] && op_src == sv_s[IDX_W-1:0] && op_wgt == sv_w[IDX_W-1:0],
            "R6", "indices held in stall", int'(op_dst), sv_d);
      end
      if (op_valid && op_ready) begin
        if (q_d.size() == 0) begin
          chk(1'b0, "R2", "unexpected extra request", int'(op_dst), -1);
        end else begin
          int ed, es, ew;
          ed = q_d.pop_front();
          es = q_s.pop_front();
          ew = q_w.pop_front();
          chk(int'(op_dst) == ed, dst_tag, "dst index", int'(op_dst), ed);
          chk(int'(op_src) == es, "R4", "src index", int'(op_src), es);
          chk(int'(op_wgt) == ew, "R4", "wgt index", int'(op_wgt), ew);
        end
        if (full_ready)
          chk(cyc == ((n_hs == 0) ? acc_cyc + 2 : last_hs + 1), "R10", "back-to-back issue cycle",
              cyc, (n_hs == 0) ? acc_cyc + 2 : last_hs + 1);
        last_hs = cyc;
        n_hs++;
      end
      prev_stall = op_valid && !op_ready;
      sv_d = int'(op_dst);
      sv_s = int'(op_src);
      sv_w = int'(op_wgt);
      if (inflight && !done)
        chk(!ins_ready, "R5", "ready low while busy", int'(ins_ready), 0);
      if (done) begin
        chk(!prev_done, "R7", "done single pulse", int'(prev_done), 0);
        chk(q_d.size() == 0, "R2", "all requests issued at done", q_d.size(), 0);
        chk(!op_valid, "R7", "no valid at done", int'(op_valid), 0);
        if (exp_zero)
          chk(cyc == acc_cyc + 1, "R8", "empty job done cycle", cyc, acc_cyc + 1);
        else
          chk(cyc == last_hs + 1, "R7", "done after last handshake", cyc, last_hs + 1);
        inflight = 1'b0;
        done_cnt++;
      end
      if (ins_valid && ins_ready) begin
        acc_cyc = cyc;
        n_hs = 0;
        inflight = !exp_zero;
      end
      prev_done = done;
    end
  end

  task automatic wr_uop(input int k, input int d, input int s, input int w);
    @(posedge clk);
    #1;
    uop_we = 1'b1;
    uop_waddr = AW'(k);
    uop_wdst = IDX_W'(d & MASK);
    uop_wsrc = IDX_W'(s & MASK);
    uop_wwgt = IDX_W'(w & MASK);
    m_d[k] = d & MASK;
    m_s[k] = s & MASK;
    m_w[k] = w & MASK;
    @(posedge clk);
    #1;
    uop_we = 1'b0;
  endtask

  task automatic run_instr(input int beg, input int en, input int ei, input int ej,
                           input int da, input int db, input int sa, input int sb,
                           input int wa, input int wb, input bit fr);
    int old;
    full_ready = fr;
    for (int y = 0; y < ei; y++)
      for (int x = 0; x < ej; x++)
        for (int u = beg; u < en; u++) begin
          q_d.push_back((da * y + db * x + m_d[u]) & MASK);
          q_s.push_back((sa * y + sb * x + m_s[u]) & MASK);
          q_w.push_back((wa * y + wb * x + m_w[u]) & MASK);
        end
    exp_zero = (ei == 0) || (ej == 0) || (en <= beg);
    old = done_cnt;
    @(posedge clk);
    #1;
    ins_valid = 1'b1;
    ins_ubeg = AW'(beg);
    ins_uend = (AW+1)'(en);
    ins_ext_i = EXT_W'(ei);
    ins_ext_j = EXT_W'(ej);
    ins_dst_a = IDX_W'(da & MASK);
    ins_dst_b = IDX_W'(db & MASK);
    ins_src_a = IDX_W'(sa & MASK);
    ins_src_b = IDX_W'(sb & MASK);
    ins_wgt_a = IDX_W'(wa & MASK);
    ins_wgt_b = IDX_W'(wb & MASK);
    @(posedge clk);
    #1;
    ins_valid = 1'b0;
    // R5: scramble the instruction inputs; the running job must ignore them
    ins_ubeg = AW'($urandom);
    ins_uend = (AW+1)'($urandom);
    ins_ext_i = EXT_W'($urandom);
    ins_ext_j = EXT_W'($urandom);
    ins_dst_a = IDX_W'($urandom);
    ins_dst_b = IDX_W'($urandom);
    ins_src_a = IDX_W'($urandom);
    ins_src_b = IDX_W'($urandom);
    ins_wgt_a = IDX_W'($urandom);
    ins_wgt_b = IDX_W'($urandom);
    wait (done_cnt != old);
    repeat (2) @(posedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int rb[4];
    int re[4];
    rb = '{0, 2, 13, 4};
    re = '{1, 5, 16, 4};
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(!op_valid, "R1", "op_valid after reset", int'(op_valid), 0);
    chk(!done, "R1", "done after reset", int'(done), 0);
    chk(ins_ready, "R1", "ins_ready after reset", int'(ins_ready), 1);
    // R9: fill the whole buffer through the write port
    for (int k = 0; k < DEPTH; k++) wr_uop(k, k * 3 + 1, k * 5 + 2, k * 7 + 100);
    // R2/R3/R4/R8/R10 sweep over extents, ranges, factors and ready patterns
    for (int ei = 0; ei < 4; ei++)
      for (int ej = 0; ej < 4; ej++)
        for (int r = 0; r < 4; r++)
          run_instr(rb[r], re[r], ei, ej, ei + 2 * r, 1 + ej, 3 * ej, (r == 1) ? 0 : 5,
                    1000 + 37 * ei, 900 + 61 * r, ((ei + ej + r) % 2) == 0);
    // R2: extent 16 with strides 1 and 0 on a single micro-op
    run_instr(0, 1, 1, 16, 0, 1, 0, 0, 3, 1, 1'b1);
    run_instr(3, 6, 2, 16, 7, 1, 1, 0, 0, 2, 1'b0);
    // R9: rewrite entries and confirm the next job uses the new values
    for (int k = 0; k < 4; k++) wr_uop(k, 2000 - k * 11, 40 + k, 500 + 3 * k);
    dst_tag = "R9";
    run_instr(0, 4, 2, 2, 5, 9, 1, 2, 3, 4, 1'b1);
    run_instr(0, 16, 2, 3, 1999, 1500, 2047, 1, 777, 1234, 1'b0);
    dst_tag = "R3";
    @(negedge clk);
    chk(ins_ready, "R5", "ready again when idle", int'(ins_ready), 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule